// File: doc/BRIEF.md
# Time-aware egress gate scheduler

This block opens and closes the eight per-traffic-class transmission gates of one egress port from a cyclic list of schedule entries. Each entry pairs an 8-bit gate mask with an interval length in nanoseconds. Software fills the list through a simple write port while the scheduler is switched off. When the block is switched on, it picks a start time from the programmed base time and then walks the list in index order, wrapping around for as long as it stays enabled.

Time comes in as a synchronized nanosecond count. Every gate change is placed on a grid of 200 ns slots, and the block reports the slot number of each change together with a one-cycle event pulse. Another schedule engine may share the same slot grid. The block compares the slot of each of its own events with the slot the other engine reports in the same cycle, and raises a conflict flag when the two are equal.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, gate_open is 8'hFF, and gate_evt and conflict are 0.
- R2: While enabled and before the start time is reached, all gates stay open (8'hFF) and no event is pulsed.
- R3: Bit i of an entry's mask drives gate_open[i], which opens traffic class i. At each entry boundary, gate_evt pulses for one cycle, gate_open takes that entry's mask, and evt_slot equals floor(boundary_ns / 200).
- R4: Entries run in index order from 0 and wrap after the last one. The cycle length is the sum of all entry intervals.
- R5: An entry with an interval of 0 is skipped: its mask never appears on gate_open.
- R6: An event fires only once floor(cur_time / 200) has reached the event's slot, never before it. Between events, gate_open holds its value while the block stays enabled.
- R7: If base_time is below cur_time when the block is enabled, the schedule starts at the first time base_time + k*cycle (k a whole number) that is at or after cur_time.
- R8: Writes to the table are ignored while enable is high.
- R9: conflict is high in exactly the cycles where gate_evt is high and the peer engine's input (peer_evt high, peer_slot) named the same slot in the cycle in which the event was detected.
- R10: When enable is low, gate_open is 8'hFF from the next cycle on, and no events fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the schedule when high; all gates open when low |
| cur_time | input | TIME_W | Synchronized current time in ns |
| base_time | input | TIME_W | Requested schedule start time in ns |
| wr_en | input | 1 | Table write strobe (ignored while enabled) |
| wr_idx | input | IDX_W | Entry index to write |
| wr_mask | input | 8 | Gate mask for the entry |
| wr_dur | input | DUR_W | Entry interval in ns (0 = skip) |
| peer_evt | input | 1 | Another engine fires an event this cycle |
| peer_slot | input | TIME_W | Slot number of the other engine's event |
| gate_open | output | 8 | Per-class gate state, 1 = open |
| gate_evt | output | 1 | One-cycle pulse on each gate change event |
| evt_slot | output | TIME_W | 200 ns slot number of the current event |
| conflict | output | 1 | Own event landed in the peer engine's slot |

## Verification
The bench builds the block with four entries, a 40-bit time and 24-bit intervals. With only four entries, one zero-interval entry is enough to test the skip, and a full wrap of the cycle takes a few thousand nanoseconds. Interval lengths that are not multiples of 200 ns test the slot rounding. A base time far in the past needs only a handful of catch-up steps to reach a start on a cycle boundary. A peer slot held on one known event slot tests that the conflict flag fires on that event and on no other.

// File: rtl/tas_pkg.sv
package tas_pkg;

    localparam int unsigned GATE_N  = 8;
    localparam int unsigned GRID_NS = 200;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SEEK = 2'd1,
        ST_WAIT = 2'd2,
        ST_RUN  = 2'd3
    } sched_state_e;

    function automatic logic [63:0] ns_to_slot(input logic [63:0] t_ns);
        return t_ns / 64'(GRID_NS);
    endfunction

endpackage

// File: rtl/tas_sched_table.sv
module tas_sched_table #(
    parameter int unsigned N_ENTRIES = 8,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned DUR_W     = 32,
    parameter int unsigned CYC_W     = DUR_W + IDX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lock,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [tas_pkg::GATE_N-1:0] wr_mask,
    input  logic [DUR_W-1:0]          wr_dur,
    output logic [tas_pkg::GATE_N-1:0] mask_o [N_ENTRIES],
    output logic [DUR_W-1:0]          dur_o  [N_ENTRIES],
    output logic [CYC_W-1:0]          cycle_o
);
    logic wr_ok;
    assign wr_ok = wr_en && !lock;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o[e] <= '1;
                dur_o[e]  <= '0;
            end else if (wr_ok && (wr_idx == IDX_W'(e))) begin
                mask_o[e] <= wr_mask;
                dur_o[e]  <= wr_dur;
            end
        end
    end

    always_comb begin
        cycle_o = '0;
        for (int e = 0; e < N_ENTRIES; e++) begin
            cycle_o = cycle_o + CYC_W'(dur_o[e]);
        end
    end
endmodule

// File: rtl/tas_entry_seek.sv
module tas_entry_seek #(
    parameter int unsigned N_ENTRIES = 8,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned DUR_W     = 32
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [DUR_W-1:0] dur_i [N_ENTRIES],
    output logic [IDX_W-1:0] next_idx,
    output logic [IDX_W-1:0] first_idx
);
    always_comb begin
        logic hit;
        next_idx = cur_idx;
        hit      = 1'b0;
        for (int k = 1; k <= N_ENTRIES; k++) begin
            int j;
            j = (int'(cur_idx) + k) % N_ENTRIES;
            if (!hit && dur_i[j] != '0) begin
                next_idx = IDX_W'(j);
                hit      = 1'b1;
            end
        end
    end

    always_comb begin
        logic hit0;
        first_idx = '0;
        hit0      = 1'b0;
        for (int j = 0; j < N_ENTRIES; j++) begin
            if (!hit0 && dur_i[j] != '0) begin
                first_idx = IDX_W'(j);
                hit0      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
    parameter int unsigned N_ENTRIES = 8,
    parameter int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    parameter int unsigned TIME_W    = 48,
    parameter int unsigned DUR_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic [TIME_W-1:0]          cur_time,
    input  logic [TIME_W-1:0]          base_time,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [tas_pkg::GATE_N-1:0] wr_mask,
    input  logic [DUR_W-1:0]           wr_dur,
    input  logic                       peer_evt,
    input  logic [TIME_W-1:0]          peer_slot,
    output logic [tas_pkg::GATE_N-1:0] gate_open,
    output logic                       gate_evt,
    output logic [TIME_W-1:0]          evt_slot,
    output logic                       conflict
);
    import tas_pkg::*;

    localparam int unsigned CYC_W = DUR_W + IDX_W;

    logic [GATE_N-1:0] ent_mask [N_ENTRIES];
    logic [DUR_W-1:0]  ent_dur  [N_ENTRIES];
    logic [CYC_W-1:0]  cycle_ns;
    logic [IDX_W-1:0]  idx_q, nxt_idx, first_idx;

    sched_state_e      state_q;
    logic [TIME_W-1:0] start_q, next_q;
    logic [TIME_W-1:0] cur_slot, start_slot, next_slot;

    tas_sched_table #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W),
        .DUR_W     (DUR_W),
        .CYC_W     (CYC_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .lock    (enable),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .wr_dur  (wr_dur),
        .mask_o  (ent_mask),
        .dur_o   (ent_dur),
        .cycle_o (cycle_ns)
    );

    tas_entry_seek #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W),
        .DUR_W     (DUR_W)
    ) u_seek (
        .cur_idx   (idx_q),
        .dur_i     (ent_dur),
        .next_idx  (nxt_idx),
        .first_idx (first_idx)
    );

    assign cur_slot   = TIME_W'(ns_to_slot(64'(cur_time)));
    assign start_slot = TIME_W'(ns_to_slot(64'(start_q)));
    assign next_slot  = TIME_W'(ns_to_slot(64'(next_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_OFF;
            start_q   <= '0;
            next_q    <= '0;
            idx_q     <= '0;
            gate_open <= '1;
            gate_evt  <= 1'b0;
            evt_slot  <= '0;
            conflict  <= 1'b0;
        end else begin
            gate_evt <= 1'b0;
            conflict <= 1'b0;
            if (!enable) begin
                state_q   <= ST_OFF;
                gate_open <= '1;
            end else begin
                unique case (state_q)
                    ST_OFF: begin
                        start_q <= base_time;
                        state_q <= ST_SEEK;
                    end
                    ST_SEEK: begin
                        if (cycle_ns != '0) begin
                            if (start_q >= cur_time) begin
                                state_q <= ST_WAIT;
                            end else begin
                                start_q <= start_q + TIME_W'(cycle_ns);
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (cur_slot >= start_slot) begin
                            state_q   <= ST_RUN;
                            idx_q     <= first_idx;
                            gate_open <= ent_mask[first_idx];
                            next_q    <= start_q + TIME_W'(ent_dur[first_idx]);
                            gate_evt  <= 1'b1;
                            evt_slot  <= start_slot;
                            conflict  <= peer_evt && (peer_slot == start_slot);
                        end
                    end
                    ST_RUN: begin
                        if (cur_slot >= next_slot) begin
                            idx_q     <= nxt_idx;
                            gate_open <= ent_mask[nxt_idx];
                            next_q    <= next_q + TIME_W'(ent_dur[nxt_idx]);
                            gate_evt  <= 1'b1;
                            evt_slot  <= next_slot;
                            conflict  <= peer_evt && (peer_slot == next_slot);
                        end
                    end
                    default: state_q <= ST_OFF;
                endcase
            end
        end
    end
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
    parameter int unsigned TIME_W = 48
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       enable,
    input logic [TIME_W-1:0]          cur_time,
    input logic                       peer_evt,
    input logic [TIME_W-1:0]          peer_slot,
    input logic [tas_pkg::GATE_N-1:0] gate_open,
    input logic                       gate_evt,
    input logic [TIME_W-1:0]          evt_slot,
    input logic                       conflict
);
    // R10
    dis_open_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (gate_open == '1 && !gate_evt));

    // R9
    conf_evt_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |-> gate_evt);

    // R9
    conf_slot_chk: assert property (@(posedge clk) disable iff (rst)
        conflict |-> ($past(peer_evt) && evt_slot == $past(peer_slot)));

    // R6
    not_early_chk: assert property (@(posedge clk) disable iff (rst)
        gate_evt |-> (evt_slot <= ($past(cur_time) / TIME_W'(tas_pkg::GRID_NS))));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !gate_evt) |-> $stable(gate_open));
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.TIME_W(TIME_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cur_time  (cur_time),
    .peer_evt  (peer_evt),
    .peer_slot (peer_slot),
    .gate_open (gate_open),
    .gate_evt  (gate_evt),
    .evt_slot  (evt_slot),
    .conflict  (conflict)
);

// File: tb/tas_gate_sched_tb_top.sv
module tas_gate_sched_tb_top;
    localparam int unsigned N      = 4;
    localparam int unsigned IW     = 2;
    localparam int unsigned TW     = 40;
    localparam int unsigned DW     = 24;
    localparam int unsigned STEPNS = 100;

    typedef struct packed {
        logic [TW-1:0] slot;
        logic [7:0]    mask;
        logic          conf;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [TW-1:0] cur_time = '0;
    logic [TW-1:0] base_time = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [7:0]    wr_mask = '0;
    logic [DW-1:0] wr_dur = '0;
    logic          peer_evt = 1'b0;
    logic [TW-1:0] peer_slot = '0;
    logic [7:0]    gate_open;
    logic          gate_evt;
    logic [TW-1:0] evt_slot;
    logic          conflict;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    exp_t exp_q[$];
    string tag = "R3";
    logic [7:0]    mdl_mask [N];
    logic [DW-1:0] mdl_dur  [N];

    always #10 clk = ~clk;

    tas_gate_sched #(.N_ENTRIES(N), .IDX_W(IW), .TIME_W(TW), .DUR_W(DW)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .cur_time(cur_time),
        .base_time(base_time), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mask(wr_mask), .wr_dur(wr_dur), .peer_evt(peer_evt),
        .peer_slot(peer_slot), .gate_open(gate_open), .gate_evt(gate_evt),
        .evt_slot(evt_slot), .conflict(conflict)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // monitor: pops the scoreboard on every event pulse
    always @(negedge clk) begin
        if (!rst && gate_evt) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {tag, " unexpected event, slot"}, 64'(evt_slot), 64'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(evt_slot == e.slot, {tag, " event slot"}, 64'(evt_slot), 64'(e.slot));
                check(gate_open == e.mask, {tag, " gate mask"}, 64'(gate_open), 64'(e.mask));
                check(conflict == e.conf, {tag, " R9 conflict"}, 64'(conflict), 64'(e.conf));
            end
        end else if (!rst && conflict) begin
            check(1'b0, "R9 conflict without event", 1, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            cur_time = cur_time + TW'(STEPNS);
        end
    endtask

    task automatic write_entry(input int i, input logic [7:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_mask = m; wr_dur = d;
        if (!enable) begin
            mdl_mask[i] = m;
            mdl_dur[i]  = d;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected event list from the model table
    task automatic push_sched(input logic [TW-1:0] base, input logic [TW-1:0] now,
                              input int n_evt, input bit pv, input logic [TW-1:0] ps);
        logic [TW-1:0] cyc, t;
        int i;
        cyc = '0;
        for (int k = 0; k < N; k++) cyc = cyc + TW'(mdl_dur[k]);
        if (base >= now) t = base;
        else t = base + ((now - base + cyc - 1) / cyc) * cyc;   // R7
        i = 0;
        while (mdl_dur[i] == 0) i = (i + 1) % N;                  // R5
        for (int k = 0; k < n_evt; k++) begin
            exp_t e;
            e.slot = t / TW'(200);
            e.mask = mdl_mask[i];
            e.conf = pv && (e.slot == ps);
            exp_q.push_back(e);
            t = t + TW'(mdl_dur[i]);
            i = (i + 1) % N;
            while (mdl_dur[i] == 0) i = (i + 1) % N;
        end
    endtask

    task automatic drain();
        int g;
        g = 0;
        while (exp_q.size() > 0 && g < 3000) begin
            step(1);
            g++;
        end
        check(exp_q.size() == 0, {tag, " all expected events seen"}, 64'(exp_q.size()), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(gate_open == 8'hFF, "R1 gate_open after reset", 64'(gate_open), 64'hFF);
        check(gate_evt == 1'b0, "R1 gate_evt after reset", 64'(gate_evt), 0);
        check(conflict == 1'b0, "R1 conflict after reset", 64'(conflict), 0);

        write_entry(0, 8'h80, DW'(1000));
        write_entry(1, 8'h7F, DW'(3050));
        write_entry(2, 8'h55, DW'(0));      // R5 skipped entry
        write_entry(3, 8'h01, DW'(650));

        // run 1: base in the future
        tag = "R3 R4 R5 R6";
        @(negedge clk);
        cur_time  = TW'(10000);
        base_time = TW'(20000);
        enable    = 1'b1;
        push_sched(TW'(20000), TW'(10000), 7, 1'b0, '0);
        step(40);
        // R2 before base: all open, nothing fired
        check(gate_open == 8'hFF, "R2 gates open before base", 64'(gate_open), 64'hFF);
        check(exp_q.size() == 7, "R2 no event before base", 64'(exp_q.size()), 7);
        // R8 write while enabled must not land in the table
        write_entry(0, 8'h33, DW'(5));
        drain();
        step(2);
        // R6 last mask holds between events
        check(gate_open == 8'h80, "R6 gate hold between events", 64'(gate_open), 64'h80);

        // R10 disable opens all gates
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(gate_open == 8'hFF, "R10 gates open after disable", 64'(gate_open), 64'hFF);
        step(20);
        check(gate_open == 8'hFF, "R10 gates stay open while off", 64'(gate_open), 64'hFF);

        // run 2: base in the past, peer engine on slot 269
        tag = "R7 R8 R9";
        @(negedge clk);
        cur_time  = TW'(50000);
        base_time = TW'(20000);
        peer_evt  = 1'b1;
        peer_slot = TW'(269);
        enable    = 1'b1;
        push_sched(TW'(20000), TW'(50000), 5, 1'b1, TW'(269));
        drain();
        @(negedge clk);
        enable = 1'b0;
        peer_evt = 1'b0;
        step(3);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            summary();
            $finish;
        end
    end
endmodule